// File: doc/BRIEF.md
# ADC Conversion Trigger and Result Register

This block is the digital control front end of a successive-approximation analog-to-digital converter. Software programs a control word that chooses the input channel, a free-running burst mode, a start mode and an edge polarity. The block turns that word into single-cycle start pulses for an external converter. A pulse can come from a software request, from one of six hardware trigger lines, or from automatic restarts in burst mode.

When the converter answers with a done pulse, the block latches the 10-bit result and the channel it belongs to into a data word. That word also carries a completion flag and an overrun flag. Reading the data word or writing the control word clears the completion flag. Writing the control word while a conversion is running abandons that conversion and starts a new one.

Top module: `adc_trig_front`

## Requirements
- R1: Address 0 holds the control word. Channel is in bits 2:0, burst enable in bit 4, start mode in bits 10:8 and edge polarity in bit 12. A read of address 0 returns these fields, and every other bit reads as zero.
- R2: When burst is off, start mode 1 issues exactly one single-cycle `conv_start` pulse for each control write. The pulse is high in the cycle after the write, and `conv_chan` equals the programmed channel.
- R3: Start modes 2 to 7 select trigger line (mode - 2). Each line passes through a two-flop synchronizer. Polarity 0 starts on a rising edge and polarity 1 on a falling edge. `conv_start` is high in the third cycle after the line changes. Edges on other lines, and edges of the opposite direction, start nothing.
- R4: A `conv_done` pulse during a conversion latches the result and the channel. Address 1 then reads the result in bits 15:6, the channel in bits 26:24, overrun in bit 30 and done in bit 31, with zeros elsewhere.
- R5: Done and overrun clear on a read of address 1 and on a control write. A done pulse that arrives in the same cycle as the read leaves done set.
- R6: Start mode 0 never starts a conversion. Trigger edges that arrive while a conversion is busy are ignored.
- R7: In burst mode a control write starts a conversion, and every done pulse restarts one in the next cycle, whatever the start mode says. Overrun is set when a new result replaces one whose done flag was still set. Overrun is set only in burst mode.
- R8: After reset both the control word and the data word read as zero, and `conv_start` is low.
- R9: A control write during a busy conversion abandons it and issues a fresh start pulse on the newly written channel.
- R10: A `conv_done` pulse while no conversion is busy changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 1 clears the flags) |
| reg_addr | input | 1 | 0 selects the control word, 1 selects the data word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| trig_in | input | 6 | Asynchronous hardware trigger lines |
| conv_start | output | 1 | Single-cycle start pulse to the converter |
| conv_chan | output | 3 | Channel of the conversion being started |
| conv_done | input | 1 | Single-cycle completion pulse from the converter |
| conv_result | input | 10 | Conversion result, valid with conv_done |

## Verification
The bench sweeps all six trigger lines under both polarities. For each combination it checks three things: the start pulse lands exactly three cycles after the line changes, a neighbouring line starts nothing, and the return edge starts nothing. A wrong line index, an inverted polarity or a missing synchronizer stage would show up as a missing, extra or mistimed start. It also drives the corners where timing meets: a read in the same cycle as a done pulse (a design that lets the clear win loses the result), a control write during a busy conversion, and stray done pulses while idle. In burst mode it lets results pile up, so a design that never sets overrun, or sets it outside burst mode, is caught. The extreme results 0 and 0x3FF are used to expose a wrong field position.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;
    localparam int CH_W      = 3;
    localparam int MODE_W    = 3;
    localparam int REG_W     = 32;
    localparam int CTL_BURST = 4;
    localparam int CTL_MODE  = 8;
    localparam int CTL_EDGE  = 12;
    localparam int DAT_RES   = 6;
    localparam int DAT_CHAN  = 24;
    localparam int DAT_OVR   = 30;
    localparam int DAT_DONE  = 31;

    localparam logic [MODE_W-1:0] MODE_NONE = 3'd0;
    localparam logic [MODE_W-1:0] MODE_NOW  = 3'd1;

    typedef struct packed {
        logic [CH_W-1:0]   chan;
        logic              burst;
        logic [MODE_W-1:0] mode;
        logic              fall_sel;
    } ctrl_t;

    typedef struct packed {
        ctrl_t           ctrl;
        logic            busy;
        logic            start;
        logic [CH_W-1:0] chan;
    } seq_t;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int N_TRIG = 6,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIG-1:0] trig_in,
    output logic [N_TRIG-1:0] rise,
    output logic [N_TRIG-1:0] fall
);
    for (genvar g = 0; g < N_TRIG; g++) begin : g_line
        logic [STAGES:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[STAGES-1:0], trig_in[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign rise[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
        assign fall[g] = ~sh_q[STAGES-1] & sh_q[STAGES];

        AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]); // R3
        AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            fall[g] |=> !fall[g]); // R3
    end
endmodule

// File: rtl/adc_trig_select.sv
module adc_trig_select
    import adc_fe_pkg::*;
#(
    parameter int N_TRIG = 6
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              fall_sel,
    input  logic [N_TRIG-1:0] rise,
    input  logic [N_TRIG-1:0] fall,
    output logic              hit
);
    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < N_TRIG; k++) begin
            if (int'(mode) == k + 2) hit = fall_sel ? fall[k] : rise[k];
        end
    end
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
    import adc_fe_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [RES_W-1:0] cap_res,
    input  logic [CH_W-1:0]  cap_chan,
    input  logic             burst,
    input  logic             rd_clr,
    input  logic             wr_clr,
    output logic [REG_W-1:0] data_word,
    output logic             done_flag
);
    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [CH_W-1:0]  chan;
        logic             done;
        logic             ovr;
    } res_t;

    res_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cap) begin
            r_d.res  = cap_res;
            r_d.chan = cap_chan;
            r_d.done = 1'b1;
            r_d.ovr  = burst & r_q.done;
        end else if (wr_clr || rd_clr) begin
            r_d.done = 1'b0;
            r_d.ovr  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        data_word = '0;
        data_word[DAT_RES +: RES_W] = r_q.res;
        data_word[DAT_CHAN +: CH_W] = r_q.chan;
        data_word[DAT_OVR]          = r_q.ovr;
        data_word[DAT_DONE]         = r_q.done;
    end
    assign done_flag = r_q.done;

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> r_q.done); // R4
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !cap) |=> !r_q.done && !r_q.ovr); // R5
    AST_OVR_BURST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ovr |-> burst); // R7
endmodule

// File: rtl/adc_trig_front.sv
module adc_trig_front
    import adc_fe_pkg::*;
#(
    parameter int N_TRIG = 6,
    parameter int RES_W  = 10,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [N_TRIG-1:0] trig_in,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result
);
    seq_t st_d, st_q;
    ctrl_t wr_ctrl;
    logic ctrl_wr, rd_clr, accept, hit, done_flag;
    logic [N_TRIG-1:0] rise, fall;
    logic [REG_W-1:0] data_word, ctrl_word;

    adc_trig_sync #(.N_TRIG(N_TRIG), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .rise(rise), .fall(fall));

    adc_trig_select #(.N_TRIG(N_TRIG)) u_sel (
        .mode(st_q.ctrl.mode), .fall_sel(st_q.ctrl.fall_sel),
        .rise(rise), .fall(fall), .hit(hit));

    adc_result_reg #(.RES_W(RES_W)) u_res (
        .clk(clk), .rst_n(rst_n), .cap(accept), .cap_res(conv_result),
        .cap_chan(st_q.chan), .burst(st_q.ctrl.burst), .rd_clr(rd_clr),
        .wr_clr(ctrl_wr), .data_word(data_word), .done_flag(done_flag));

    assign ctrl_wr = reg_wr && !reg_addr;
    assign rd_clr  = reg_rd && reg_addr;
    assign accept  = conv_done && st_q.busy && !ctrl_wr;

    always_comb begin
        wr_ctrl.chan     = reg_wdata[CH_W-1:0];
        wr_ctrl.burst    = reg_wdata[CTL_BURST];
        wr_ctrl.mode     = reg_wdata[CTL_MODE +: MODE_W];
        wr_ctrl.fall_sel = reg_wdata[CTL_EDGE];
    end

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (ctrl_wr) begin
            st_d.ctrl = wr_ctrl;
            if (wr_ctrl.burst || wr_ctrl.mode == MODE_NOW || st_q.busy) begin
                st_d.start = 1'b1;
                st_d.busy  = 1'b1;
                st_d.chan  = wr_ctrl.chan;
            end
        end else if (accept) begin
            st_d.busy = 1'b0;
            if (st_q.ctrl.burst) begin
                st_d.start = 1'b1;
                st_d.busy  = 1'b1;
                st_d.chan  = st_q.ctrl.chan;
            end
        end else if (!st_q.busy && !st_q.ctrl.burst && hit) begin
            st_d.start = 1'b1;
            st_d.busy  = 1'b1;
            st_d.chan  = st_q.ctrl.chan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CH_W-1:0]          = st_q.ctrl.chan;
        ctrl_word[CTL_BURST]         = st_q.ctrl.burst;
        ctrl_word[CTL_MODE +: MODE_W] = st_q.ctrl.mode;
        ctrl_word[CTL_EDGE]          = st_q.ctrl.fall_sel;
    end

    assign reg_rdata  = reg_addr ? data_word : ctrl_word;
    assign conv_start = st_q.start;
    assign conv_chan  = st_q.chan;

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> st_q.busy); // R2
    AST_BURST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.burst && conv_done && st_q.busy && !ctrl_wr) |=> conv_start); // R7
    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !st_q.busy && !done_flag && !ctrl_wr) |=> !done_flag); // R10
    AST_BUSY_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && st_q.busy) |=> conv_start); // R9
    AST_MODE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && !st_q.busy && !st_q.ctrl.burst && st_q.ctrl.mode == MODE_NONE) |=> !conv_start); // R6
endmodule

// File: tb/tb_adc_trig_front.sv
module tb_adc_trig_front;
    logic clk = 0, rst_n = 0;
    logic reg_wr = 0, reg_rd = 0, reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic [5:0] trig_in = 0;
    logic conv_start, conv_done = 0;
    logic [2:0] conv_chan;
    logic [9:0] conv_result = 0;
    int checks = 0, errors = 0, n_start = 0;
    logic [31:0] v;

    always #4 clk = ~clk;

    adc_trig_front dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trig_in(trig_in), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_result(conv_result));

    always @(posedge clk) if (rst_n && conv_start) n_start++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] dword(input bit d, input bit o, input int ch, input int res);
        return {d, o, 3'b0, 3'(ch), 8'b0, 10'(res), 6'b0};
    endfunction

    task automatic wr_ctrl(input int ch, input bit burst, input int mode, input bit fe);
        @(negedge clk);
        reg_wdata = 0;
        reg_wdata[2:0] = 3'(ch); reg_wdata[4] = burst;
        reg_wdata[10:8] = 3'(mode); reg_wdata[12] = fe;
        reg_addr = 0; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic peek(input bit a, output logic [31:0] r);
        reg_addr = a; #1 r = reg_rdata;
    endtask

    task automatic rd_data(output logic [31:0] r);
        @(negedge clk);
        reg_addr = 1; reg_rd = 1; #1 r = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic pulse_done(input int res);
        @(negedge clk);
        conv_done = 1; conv_result = 10'(res);
        @(negedge clk);
        conv_done = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0;
        logic [31:0] exp;
        idle(3); rst_n = 1; @(negedge clk);
        // R8 reset state
        peek(0, v); chk(v == 0, "R8 ctrl reset", v, 0);
        peek(1, v); chk(v == 0, "R8 data reset", v, 0);
        chk(conv_start == 0, "R8 no start", 32'(conv_start), 0);

        // R1 readback layout
        wr_ctrl(3, 0, 0, 1);
        peek(0, v); chk(v == 32'h0000_1003, "R1 readback", v, 32'h1003);
        wr_ctrl(7, 0, 6, 0);
        peek(0, v); chk(v == 32'h0000_0607, "R1 readback mode", v, 32'h0607);
        chk(n_start == 0, "R6 mode 6 no spurious start", n_start, 0);

        // R2 immediate start, R4 extreme result
        s0 = n_start;
        wr_ctrl(5, 0, 1, 0);
        chk(conv_start == 1, "R2 start after write", 32'(conv_start), 1);
        chk(conv_chan == 5, "R2 channel", 32'(conv_chan), 5);
        @(negedge clk);
        chk(conv_start == 0, "R2 single cycle", 32'(conv_start), 0);
        idle(10);
        chk(n_start == s0 + 1, "R2 one per write", n_start, s0 + 1);
        pulse_done(10'h3FF);
        peek(1, v); exp = dword(1, 0, 5, 10'h3FF);
        chk(v == exp, "R4 result 3FF", v, exp);
        rd_data(v); chk(v == exp, "R4 read value", v, exp);
        peek(1, v); exp = dword(0, 0, 5, 10'h3FF);
        chk(v == exp, "R5 read clears done", v, exp);

        // R4 zero result, R5 control write clears
        wr_ctrl(2, 0, 1, 0);
        pulse_done(0);
        peek(1, v); exp = dword(1, 0, 2, 0);
        chk(v == exp, "R4 result 0", v, exp);
        s0 = n_start;
        wr_ctrl(2, 0, 0, 0);
        peek(1, v); exp = dword(0, 0, 2, 0);
        chk(v == exp, "R5 ctrl write clears done", v, exp);
        idle(5);
        chk(n_start == s0, "R6 mode 0 no start", n_start, s0);

        // R10 stray done while idle
        pulse_done(10'h155);
        peek(1, v); chk(v == exp, "R10 idle done ignored", v, exp);

        // R3 trigger sweep
        for (int i = 0; i < 6; i++) begin
            for (int e = 0; e < 2; e++) begin
                int j;
                j = (i + 1) % 6;
                wr_ctrl(0, 0, 0, 0);
                trig_in = {6{e[0]}};
                idle(5);
                s0 = n_start;
                wr_ctrl(i, 0, 2 + i, e[0]);
                chk(conv_start == 0, "R3 no start on trigger-mode write", 32'(conv_start), 0);
                trig_in[j] = ~e[0];
                idle(5);
                chk(n_start == s0, "R3 other line ignored", n_start, s0);
                trig_in[i] = ~e[0];
                idle(2);
                chk(conv_start == 0, "R3 not before third cycle", 32'(conv_start), 0);
                @(negedge clk);
                chk(conv_start == 1, "R3 start third cycle", 32'(conv_start), 1);
                chk(conv_chan == 3'(i), "R3 channel", 32'(conv_chan), i);
                pulse_done(i * 100 + e * 37);
                peek(1, v); exp = dword(1, 0, i, i * 100 + e * 37);
                chk(v == exp, "R4 trigger result", v, exp);
                s0 = n_start;
                trig_in[i] = e[0];
                idle(5);
                chk(n_start == s0, "R3 opposite edge ignored", n_start, s0);
                rd_data(v);
            end
        end

        // R6 edges during busy ignored
        wr_ctrl(0, 0, 0, 0);
        trig_in = 0; idle(5);
        wr_ctrl(1, 0, 2, 0);
        s0 = n_start;
        trig_in[0] = 1; idle(4);
        chk(n_start == s0 + 1, "R6 first edge starts", n_start, s0 + 1);
        trig_in[0] = 0; idle(3);
        trig_in[0] = 1; idle(6);
        chk(n_start == s0 + 1, "R6 busy edge ignored", n_start, s0 + 1);
        pulse_done(7);
        trig_in[0] = 0; idle(3);
        trig_in[0] = 1; idle(5);
        chk(n_start == s0 + 2, "R6 edge after done starts", n_start, s0 + 2);
        pulse_done(8);
        rd_data(v);

        // R9 write while busy
        wr_ctrl(3, 0, 1, 0);
        wr_ctrl(4, 0, 0, 0);
        chk(conv_start == 1, "R9 restart pulse", 32'(conv_start), 1);
        chk(conv_chan == 4, "R9 new channel", 32'(conv_chan), 4);
        pulse_done(10'h123);
        peek(1, v); exp = dword(1, 0, 4, 10'h123);
        chk(v == exp, "R9 result of new conversion", v, exp);

        // R5 done in same cycle as read wins
        wr_ctrl(6, 0, 1, 0);
        @(negedge clk);
        reg_addr = 1; reg_rd = 1; conv_done = 1; conv_result = 10'h2A5;
        @(negedge clk);
        reg_rd = 0; conv_done = 0;
        peek(1, v); exp = dword(1, 0, 6, 10'h2A5);
        chk(v == exp, "R5 done beats read clear", v, exp);
        rd_data(v);

        // R7 burst
        s0 = n_start;
        wr_ctrl(6, 1, 0, 0);
        chk(conv_start == 1, "R7 burst start", 32'(conv_start), 1);
        pulse_done(10'h011);
        chk(conv_start == 1, "R7 burst restart", 32'(conv_start), 1);
        peek(1, v); exp = dword(1, 0, 6, 10'h011);
        chk(v == exp, "R7 first result no overrun", v, exp);
        pulse_done(10'h022);
        peek(1, v); exp = dword(1, 1, 6, 10'h022);
        chk(v == exp, "R7 overrun set", v, exp);
        rd_data(v);
        peek(1, v); exp = dword(0, 0, 6, 10'h022);
        chk(v == exp, "R7 read clears overrun", v, exp);
        pulse_done(10'h033);
        peek(1, v); exp = dword(1, 0, 6, 10'h033);
        chk(v == exp, "R7 no overrun after read", v, exp);
        chk(n_start == s0 + 3, "R7 start count", n_start, s0 + 3);
        wr_ctrl(0, 0, 0, 0);
        pulse_done(1);
        peek(1, v); exp = dword(1, 0, 0, 1);
        chk(v == exp, "R7 no overrun outside burst", v, exp);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule